// File: doc/BRIEF.md
# Four-Tap Cubic Sample Interpolator

This block turns four neighbouring 8-bit source samples along one image axis into a single interpolated sample. A fractional phase tells it where the new sample lies between the second and third source samples. From that phase the block derives four cubic weights in hardware on every cycle. The two outer weights are never positive. It then forms the weighted sum of the samples, rounds it and clips it to the 8-bit pixel range.

A scaler uses two instances of the same block. The first runs down the columns, and its results feed the second, which runs along the rows. Each instance accepts one sample set per clock and returns its result after a fixed delay. This lets the surrounding line-buffer and address logic line up results by counting cycles only.

Top module: `cubic_interp4`

## Requirements
- R1: The phase `ph` is a 6-bit unsigned fraction with value ph/64. When ph is 0 the result equals sample `p1` exactly, for any pixels.
- R2: With t = 64 − ph, the exact weights in units of 2^-18 are: a = −t²·ph for `p0`, b = 4096·t + 2·t²·ph − t·ph² for `p1`, c = 4096·ph + 2·t·ph² − t²·ph for `p2`, d = −t·ph² for `p3`.
- R3: The weights a, c and d are quantised to 12 fraction bits as floor((x + 32) / 64). The weight of `p1` is 4096 minus the other three, so the four quantised weights always sum to exactly 4096.
- R4: With A the sum of quantised weight times pixel, the result before clipping is floor((A + 2048) / 4096), which rounds half up.
- R5: A negative result is output as 0, and a result above 255 is output as 255.
- R6: `o_vld` is high in cycle n+3 exactly when `i_vld` was high in cycle n, and the data of that input set appears in the same cycle.
- R7: Inputs presented while `i_vld` is low have no effect. `o_vld` stays low for them and `o_pix` keeps its last value while `o_vld` is low.
- R8: After a synchronous active-low reset, `o_vld` is 0 and `o_pix` is 0, even if `i_vld` was high during reset.
- R9: A new sample set is accepted on every cycle, and back-to-back sets produce back-to-back results in input order.
- R10: When all four pixels are equal, the result equals that pixel for every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| i_vld | input | 1 | Input sample set is valid this cycle |
| i_ph | input | 6 | Fractional phase measured from `p1` toward `p2` |
| i_p0 | input | 8 | Source sample at position i |
| i_p1 | input | 8 | Source sample at position i+1 |
| i_p2 | input | 8 | Source sample at position i+2 |
| i_p3 | input | 8 | Source sample at position i+3 |
| o_vld | output | 1 | Result valid |
| o_pix | output | 8 | Rounded, clipped interpolated sample |

## Verification
A wrong weight, such as a bad sign on an outer tap or a lost residue in the `p1` weight, shows up three cycles later as a result that is off by one or more codes. It shows first on uniform pixel sets and on step edges, where the exact answer is known. A mistake in the rounding or clipping stage shows up on the overshoot and undershoot patterns in that same cycle, as a value that wrapped around instead of sticking at 0 or 255. A fault in the valid pipeline or its load enables shows either as a result in the wrong cycle or as `o_pix` changing while `o_vld` is low. The scoreboard catches both at the first affected cycle.

// File: rtl/cubic_interp_pkg.sv
// Package: shared defaults for the four-tap cubic interpolator.
// Assumes: the parameter defaults below are used unless an instance overrides them.
package cubic_interp_pkg;
    localparam int NTAP      = 4;   // taps per interpolation
    localparam int PIX_W_DEF = 8;   // pixel width
    localparam int PH_W_DEF  = 6;   // phase width
    localparam int WF_DEF    = 12;  // weight fraction bits

    // Signed weight width: sign, two integer bits, fraction bits.
    function automatic int weight_width(input int wf);
        return wf + 3;
    endfunction
endpackage

// File: rtl/cubic_weight_stage.sv
// Module: cubic_weight_stage
// Pipeline stage 1. Derives the four cubic weights from the phase and
// registers them together with the pixels.
// Assumes: 3*PH_W bits of intermediate fraction hold the weights exactly.
//   They are then rounded half up to WF fraction bits, and the residue of
//   that rounding goes into the weight of tap 1.
module cubic_weight_stage
    import cubic_interp_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int PH_W  = PH_W_DEF,
    parameter int WF    = WF_DEF,
    parameter int WW    = weight_width(WF_DEF)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [PH_W-1:0]         in_ph,
    input  logic [PIX_W-1:0]        in_pix [NTAP],
    output logic                    st_vld,
    output logic signed [WW-1:0]    st_w   [NTAP],
    output logic [PIX_W-1:0]        st_pix [NTAP]
);
    localparam int EXF   = 3 * PH_W;        // exact fraction bits
    localparam int EXW   = EXF + 3;         // exact weight width
    localparam int SHIFT = EXF - WF;        // bits dropped by quantising
    localparam int ONE_PH = 1 << PH_W;
    localparam logic signed [WW-1:0] ONE_W = WW'(1) <<< WF;

    logic [PH_W:0]            t_u;
    logic signed [EXW-1:0]    t_x, s_x, term_a, term_b;
    logic signed [EXW-1:0]    ex_w [NTAP];
    logic signed [WW-1:0]     q_w  [NTAP];
    logic signed [WW-1:0]     w1_fold;

    // Exact cubic weights in units of 2^-EXF.
    always_comb begin
        t_u    = ONE_PH[PH_W:0] - {1'b0, in_ph};
        t_x    = EXW'(t_u);
        s_x    = EXW'(in_ph);
        term_a = t_x * t_x * s_x;
        term_b = t_x * s_x * s_x;
        ex_w[0] = -term_a;
        ex_w[1] = (t_x <<< (2 * PH_W)) + (term_a <<< 1) - term_b;
        ex_w[2] = (s_x <<< (2 * PH_W)) + (term_b <<< 1) - term_a;
        ex_w[3] = -term_b;
    end

    // Quantise each weight to WF fraction bits; the variant depends on SHIFT.
    for (genvar k = 0; k < NTAP; k++) begin : g_quant
        if (SHIFT > 0) begin : g_round
            localparam logic signed [EXW-1:0] HALF_Q = EXW'(1) <<< (SHIFT - 1);
            assign q_w[k] = WW'((ex_w[k] + HALF_Q) >>> SHIFT);
        end else if (SHIFT == 0) begin : g_exact
            assign q_w[k] = WW'(ex_w[k]);
        end else begin : g_widen
            assign q_w[k] = WW'(ex_w[k] <<< (-SHIFT));
        end
    end

    // Tap-1 weight absorbs the rounding residue so the weights sum to one.
    always_comb begin
        w1_fold = ONE_W - q_w[0] - q_w[2] - q_w[3];
    end

    // Stage register: loads weights and pixels only for valid sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld <= 1'b0;
            for (int k = 0; k < NTAP; k++) begin
                st_w[k]   <= '0;
                st_pix[k] <= '0;
            end
        end else begin
            st_vld <= in_vld;
            if (in_vld) begin
                st_w[0] <= q_w[0];
                st_w[1] <= w1_fold;
                st_w[2] <= q_w[2];
                st_w[3] <= q_w[3];
                for (int k = 0; k < NTAP; k++) st_pix[k] <= in_pix[k];
            end
        end
    end

    // R1
    // zero_phase_chk: a zero phase gives unit weight on tap 1 only.
    zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_ph == '0) |=>
            (st_w[1] == ONE_W && st_w[0] == '0 && st_w[2] == '0 && st_w[3] == '0));

    // R2
    // outer_sign_chk: the outer weights that were loaded are never positive.
    outer_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_vld) |-> (st_w[0] <= 0 && st_w[3] <= 0));
endmodule

// File: rtl/cubic_round_sat.sv
// Module: cubic_round_sat
// Rounds a fixed-point accumulator half up to an integer and clips it to
// the unsigned pixel range.
// Assumes: the accumulator carries WF fraction bits and AW > PIX_W + WF.
module cubic_round_sat #(
    parameter int AW    = 26,
    parameter int WF    = 12,
    parameter int PIX_W = 8
) (
    input  logic signed [AW-1:0] acc,
    output logic [PIX_W-1:0]     pix
);
    localparam logic signed [AW-1:0] HALF_O = AW'(1) <<< (WF - 1);
    localparam logic signed [AW-1:0] MAXV   = AW'((1 << PIX_W) - 1);

    logic signed [AW-1:0] rnd;

    // Round half up, then clip to [0, 2^PIX_W - 1].
    always_comb begin
        rnd = (acc + HALF_O) >>> WF;
        if (rnd < 0)
            pix = '0;
        else if (rnd > MAXV)
            pix = '1;
        else
            pix = rnd[PIX_W-1:0];
    end
endmodule

// File: rtl/cubic_mac_stage.sv
// Module: cubic_mac_stage
// Pipeline stages 2 and 3. Multiplies each weight by its pixel, registers
// the products, then sums, rounds and clips them into the output register.
// Assumes: the weights are signed with WF fraction bits and the pixels are unsigned.
module cubic_mac_stage
    import cubic_interp_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int WF    = WF_DEF,
    parameter int WW    = weight_width(WF_DEF)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_vld,
    input  logic signed [WW-1:0]    st_w   [NTAP],
    input  logic [PIX_W-1:0]        st_pix [NTAP],
    output logic                    out_vld,
    output logic [PIX_W-1:0]        out_pix
);
    localparam int PW = WW + PIX_W + 1;  // product width
    localparam int AW = PW + 2;          // accumulator width for four taps

    logic                 pr_vld;
    logic signed [PW-1:0] prod [NTAP];
    logic signed [AW-1:0] sum;
    logic [PIX_W-1:0]     clipped;

    // Stage 2: one signed product per tap, loaded only for valid sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_vld <= 1'b0;
            for (int k = 0; k < NTAP; k++) prod[k] <= '0;
        end else begin
            pr_vld <= st_vld;
            if (st_vld)
                for (int k = 0; k < NTAP; k++)
                    prod[k] <= PW'(st_w[k]) * PW'($signed({1'b0, st_pix[k]}));
        end
    end

    // Adder tree across the registered products.
    always_comb begin
        sum = '0;
        for (int k = 0; k < NTAP; k++) sum = sum + AW'(prod[k]);
    end

    cubic_round_sat #(
        .AW    (AW),
        .WF    (WF),
        .PIX_W (PIX_W)
    ) u_round (
        .acc (sum),
        .pix (clipped)
    );

    // Stage 3: output register, which holds its value between valid results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_pix <= '0;
        end else begin
            out_vld <= pr_vld;
            if (pr_vld) out_pix <= clipped;
        end
    end

    // R5
    // neg_clamp_chk: a negative sum leaves zero in the output register.
    neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_vld && sum < 0) |=> (out_pix == '0));

    // R6
    // pipe_step_chk: stage-2 valid moves to the output on the next cycle.
    pipe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pr_vld |=> out_vld);
endmodule

// File: rtl/cubic_interp4.sv
// Module: cubic_interp4 (top)
// Four-tap cubic interpolator for one axis. It takes one sample set per
// cycle and returns the result three cycles later.
// Assumes: the caller supplies the phase relative to sample p1 and aligns
//   results to inputs by the fixed latency.
module cubic_interp4
    import cubic_interp_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int PH_W  = PH_W_DEF,
    parameter int WF    = WF_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_vld,
    input  logic [PH_W-1:0]  i_ph,
    input  logic [PIX_W-1:0] i_p0,
    input  logic [PIX_W-1:0] i_p1,
    input  logic [PIX_W-1:0] i_p2,
    input  logic [PIX_W-1:0] i_p3,
    output logic             o_vld,
    output logic [PIX_W-1:0] o_pix
);
    localparam int WW = weight_width(WF);

    logic [PIX_W-1:0]        in_pix [NTAP];
    logic                    st_vld;
    logic signed [WW-1:0]    st_w   [NTAP];
    logic [PIX_W-1:0]        st_pix [NTAP];
    logic [1:0]              warm;
    logic                    in_uniform;

    // Gather the input pixels into a tap array.
    always_comb begin
        in_pix[0]  = i_p0;
        in_pix[1]  = i_p1;
        in_pix[2]  = i_p2;
        in_pix[3]  = i_p3;
        in_uniform = (i_p0 == i_p1) && (i_p1 == i_p2) && (i_p2 == i_p3);
    end

    cubic_weight_stage #(
        .PIX_W (PIX_W),
        .PH_W  (PH_W),
        .WF    (WF),
        .WW    (WW)
    ) u_weights (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (i_vld),
        .in_ph  (i_ph),
        .in_pix (in_pix),
        .st_vld (st_vld),
        .st_w   (st_w),
        .st_pix (st_pix)
    );

    cubic_mac_stage #(
        .PIX_W (PIX_W),
        .WF    (WF),
        .WW    (WW)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_vld  (st_vld),
        .st_w    (st_w),
        .st_pix  (st_pix),
        .out_vld (o_vld),
        .out_pix (o_pix)
    );

    // Counts edges since reset (saturating) so that checks cover full pipelines only.
    always_ff @(posedge clk) begin
        if (!rst_n)             warm <= 2'd0;
        else if (warm != 2'd3)  warm <= warm + 2'd1;
    end

    // R6
    // latency_chk: output valid is the input valid three cycles earlier.
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (o_vld == $past(i_vld, 3)));

    // R7
    // hold_chk: the output sample does not move while no result is valid.
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && !o_vld) |-> $stable(o_pix));

    // R10
    // uniform_chk: equal pixels come back unchanged at any phase.
    uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(i_vld, 3) && $past(in_uniform, 3))
            |-> (o_pix == $past(i_p1, 3)));
endmodule

// File: tb/tb_cubic_interp4.sv
`timescale 1ns/1ps
module tb_cubic_interp4;
    localparam int PH_W = 6;
    localparam int WF   = 12;
    localparam int SH   = 3 * PH_W - WF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_vld = 1'b0;
    logic [5:0] i_ph = '0;
    logic [7:0] i_p0 = '0, i_p1 = '0, i_p2 = '0, i_p3 = '0;
    logic       o_vld;
    logic [7:0] o_pix;

    typedef struct {
        int     exp;
        longint stamp;
        string  req;
    } item_t;

    item_t  sb[$];
    int     n_tests = 0;
    int     n_fail  = 0;
    longint cyc     = 0;
    int     last_out = 0;
    bit     mon_on  = 1'b0;
    bit     done    = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cubic_interp4 dut (
        .clk   (clk),
        .rst_n (rst_n),
        .i_vld (i_vld),
        .i_ph  (i_ph),
        .i_p0  (i_p0),
        .i_p1  (i_p1),
        .i_p2  (i_p2),
        .i_p3  (i_p3),
        .o_vld (o_vld),
        .o_pix (o_pix)
    );

    // Reference following R2, R3, R4 and R5.
    function automatic int ref_out(int k, int a0, int a1, int a2, int a3);
        longint t = (1 << PH_W) - k;
        longint e0 = -(t * t * k);
        longint e2 = (longint'(k) << (2 * PH_W)) + 2 * t * k * k - t * t * k;
        longint e3 = -(t * k * k);
        longint q0 = (e0 + (64'sd1 << (SH - 1))) >>> SH;
        longint q2 = (e2 + (64'sd1 << (SH - 1))) >>> SH;
        longint q3 = (e3 + (64'sd1 << (SH - 1))) >>> SH;
        longint q1 = (64'sd1 << WF) - q0 - q2 - q3;
        longint acc = q0 * a0 + q1 * a1 + q2 * a2 + q3 * a3;
        longint y = (acc + (64'sd1 << (WF - 1))) >>> WF;
        if (y < 0)   y = 0;
        if (y > 255) y = 255;
        return int'(y);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Driver: presents one valid set and queues its expected result.
    task automatic send(int k, int a0, int a1, int a2, int a3, string tag);
        item_t it;
        @(negedge clk);
        i_vld = 1'b1; i_ph = 6'(k);
        i_p0 = 8'(a0); i_p1 = 8'(a1); i_p2 = 8'(a2); i_p3 = 8'(a3);
        it.stamp = cyc + 3;
        if (k == 0) begin
            it.exp = a1;           // R1: zero phase returns p1
            it.req = "R1";
        end else if (a0 == a1 && a1 == a2 && a2 == a3) begin
            it.exp = a1;           // R10: equal pixels pass through
            it.req = "R10";
        end else begin
            it.exp = ref_out(k, a0, a1, a2, a3);
            it.req = tag;
        end
        sb.push_back(it);
    endtask

    // Idle cycles carrying junk data with i_vld low (R7).
    task automatic idle(int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            i_vld = 1'b0;
            i_ph = 6'($urandom); i_p0 = 8'($urandom); i_p1 = 8'($urandom);
            i_p2 = 8'($urandom); i_p3 = 8'($urandom);
        end
    endtask

    // Monitor: compares results against the scoreboard away from the active edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (o_vld) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R6", "unexpected o_vld", 1, 0);
                    end else begin
                        it = sb.pop_front();
                        check(int'(o_pix) == it.exp, it.req, "o_pix", int'(o_pix), it.exp);
                        check(it.stamp == cyc, "R6", "result cycle", int'(cyc), int'(it.stamp));
                    end
                    last_out = int'(o_pix);
                end else begin
                    if (sb.size() > 0 && sb[0].stamp <= cyc) begin
                        it = sb.pop_front();
                        check(1'b0, "R6", "missing o_vld", 0, 1);
                    end
                    check(int'(o_pix) == last_out, "R7", "o_pix held while idle", int'(o_pix), last_out);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset with junk valid inputs present.
        repeat (5) begin
            @(negedge clk);
            i_vld = 1'b1; i_ph = 6'($urandom); i_p0 = 8'($urandom);
            i_p1 = 8'($urandom); i_p2 = 8'($urandom); i_p3 = 8'($urandom);
        end
        @(negedge clk);
        rst_n = 1'b1; i_vld = 1'b0;
        @(negedge clk);
        check(o_vld == 1'b0, "R8", "o_vld after reset", int'(o_vld), 0);
        check(o_pix == 8'd0, "R8", "o_pix after reset", int'(o_pix), 0);
        mon_on = 1'b1;
        idle(3);

        // Ramp, step, overshoot and undershoot across every phase.
        for (int k = 0; k < 64; k++) send(k, 10, 60, 110, 160, "R2,R3,R4");
        idle(4);
        for (int k = 0; k < 64; k++) send(k, 0, 0, 255, 255, "R4");
        for (int k = 0; k < 64; k++) send(k, 0, 255, 255, 0, "R5");
        idle(2);
        for (int k = 0; k < 64; k++) send(k, 255, 0, 0, 255, "R5");
        for (int k = 0; k < 64; k++) send(k, 200, 30, 220, 15, "R3");
        for (int k = 0; k < 64; k++) send(k, (k * 4) & 255, (k * 4) & 255, (k * 4) & 255, (k * 4) & 255, "R10");
        send(63, 255, 255, 255, 255, "R10");
        send(63, 0, 0, 0, 0, "R10");
        idle(3);

        // R9: back-to-back random sets.
        for (int j = 0; j < 200; j++)
            send(int'($urandom % 64), int'($urandom % 256), int'($urandom % 256),
                 int'($urandom % 256), int'($urandom % 256), "R9");

        // Random sets with gaps (R7 between them).
        for (int j = 0; j < 200; j++) begin
            if ($urandom % 2) idle(int'($urandom % 3) + 1);
            send(int'($urandom % 64), int'($urandom % 256), int'($urandom % 256),
                 int'($urandom % 256), int'($urandom % 256), "R4");
        end
        idle(8);
        check(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule